// File: doc/BRIEF.md
# SPI Register-Access Target

This block is an SPI target that gives an external host byte-wide read and write access to a bank of 64 eight-bit registers. The host pulls chip select low for the whole transaction. While chip select is high, the serial clock rests high. The host changes data while the clock is low, and both ends capture it on the rising clock edge. The first byte of every transaction is a command, made of a direction flag, an increment flag and a register address. Any number of eight-clock data blocks may follow in the same transaction, until chip select rises.

The serial pins are brought into the system clock domain through synchronizer stages. All decoding happens on the system clock. A static configuration input chooses one of two wirings. In four-wire operation, read data leaves on a dedicated output pin. In three-wire operation, read data is returned on the output side of a shared bidirectional data line, and the dedicated pin is never enabled. Register contents carry no meaning inside this block. Every register resets to zero.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset, and whenever chip select is high, both output enables (`sdoOe` and `sdioOe`) are low.
- R2: The command byte is the first 8 bits after chip select falls. Bit order on the wire is: direction flag first (1 = read, 0 = write), then the increment flag, then the 6-bit register address, most significant bit first.
- R3: A write of 16 clocks stores the 8 data bits, received most significant bit first, into the addressed register. The store takes effect after the eighth data bit is sampled.
- R4: On a read, the output enable stays low during the command byte. It rises at the first falling clock edge of the data phase (bit 8). The addressed register is then presented most significant bit first, one bit per falling edge.
- R5: With the increment flag set, each further data block addresses the next register. The address wraps from 63 back to 0.
- R6: With the increment flag clear, every data block of the transaction uses the same register.
- R7: When chip select rises before the eighth bit of a byte, that byte is abandoned. No register changes, and the next transaction starts again with a command byte.
- R8: With `threeWire` high, read data and its enable appear on `sdioOut`/`sdioOe`, and `sdoOe` stays low. Writes arrive on `sdi` as in four-wire operation.
- R9: With `threeWire` low, read data and its enable appear on `sdo`/`sdoOe`, and `sdioOe` stays low.
- R10: After reset, every register reads back as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the serial clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sdi | input | 1 | Serial data in (input side of the shared line in three-wire operation) |
| threeWire | input | 1 | Static configuration: 1 selects shared-line read data |
| sdo | output | 1 | Four-wire read data |
| sdoOe | output | 1 | Output enable for `sdo` |
| sdioOut | output | 1 | Three-wire read data toward the shared line |
| sdioOe | output | 1 | Output enable for the shared line |

## Verification
The bench builds the block with its default 8-bit data width, which gives 6-bit addresses and 64 registers, and with two synchronizer stages. The bank is small enough that the bench can sweep it completely:
- one incrementing burst writes all 64 registers with an arithmetic pattern;
- bursts read the bank back from offset 0 and from offset 10, so every address is compared and the wrap from 63 to 0 is crossed;
- single accesses, repeated-address blocks, aborts cut off inside a command byte and inside a data byte, and three-wire transfers are then checked against the bench's own model of the registers.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  // One-cycle strobes from the control sequencer to the datapath
  typedef struct packed {
    logic shiftIn;    // rising serial clock: capture one input bit
    logic cmdLoad;    // eighth bit of the command byte captured
    logic blockDone;  // eighth bit of a data block captured
    logic shiftOut;   // falling serial clock in a read data phase
  } spiStrobes_t;
endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csNPin,
  input  logic        sclkPin,
  input  logic        sdiPin,
  input  logic        readMode,
  output spiStrobes_t strobes,
  output logic        sdiBit,
  output logic        driveOe
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [SYNC_STAGES-1:0] csSync, sclkSync, sdiSync;
  logic csS, sclkS, sclkPrev;
  logic [CNT_W-1:0] bitCnt;
  logic cmdPhase;
  logic sclkRise, sclkFall, lastBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync   <= '1;
      sclkSync <= '1;
      sdiSync  <= '0;
      sclkPrev <= 1'b1;
    end else begin
      csSync   <= {csSync[SYNC_STAGES-2:0], csNPin};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkPin};
      sdiSync  <= {sdiSync[SYNC_STAGES-2:0], sdiPin};
      sclkPrev <= sclkS;
    end
  end

  assign csS    = csSync[SYNC_STAGES-1];
  assign sclkS  = sclkSync[SYNC_STAGES-1];
  assign sdiBit = sdiSync[SYNC_STAGES-1];

  assign sclkRise = !csS && sclkS && !sclkPrev;
  assign sclkFall = !csS && !sclkS && sclkPrev;
  assign lastBit  = (bitCnt == LAST_BIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      cmdPhase <= 1'b1;
      driveOe  <= 1'b0;
    end else if (csS) begin
      bitCnt   <= '0;
      cmdPhase <= 1'b1;
      driveOe  <= 1'b0;
    end else begin
      if (sclkRise) begin
        bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
        if (lastBit) cmdPhase <= 1'b0;
      end
      if (sclkFall && !cmdPhase && readMode) driveOe <= 1'b1;
    end
  end

  always_comb begin
    strobes.shiftIn   = sclkRise;
    strobes.cmdLoad   = sclkRise && lastBit && cmdPhase;
    strobes.blockDone = sclkRise && lastBit && !cmdPhase;
    strobes.shiftOut  = sclkFall && !cmdPhase && readMode;
  end

  // R1
  cs_idle_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> !driveOe);

  // R4
  cmd_no_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdPhase |-> !driveOe);

  // R7
  abort_no_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    csS |-> !strobes.blockDone && !strobes.cmdLoad);
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  spiStrobes_t strobes,
  input  logic        sdiBit,
  output logic        readMode,
  output logic        txBit
);
  localparam int ADDR_W = DATA_W - 2;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  logic [DATA_W-1:0] regBank [DEPTH];
  logic [ADDR_W-1:0] addrReg, nextAddr;
  logic              incFlag;
  logic [DATA_W-1:0] txShift;

  assign rxNext   = {rxShift, sdiBit};
  assign nextAddr = incFlag ? addrReg + ADDR_W'(1) : addrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift  <= '0;
      readMode <= 1'b0;
      incFlag  <= 1'b0;
      addrReg  <= '0;
      txShift  <= '0;
      txBit    <= 1'b0;
    end else begin
      if (strobes.shiftIn) rxShift <= rxNext[DATA_W-2:0];
      if (strobes.cmdLoad) begin
        readMode <= rxNext[DATA_W-1];
        incFlag  <= rxNext[DATA_W-2];
        addrReg  <= rxNext[ADDR_W-1:0];
        txShift  <= regBank[rxNext[ADDR_W-1:0]];
      end else if (strobes.blockDone) begin
        addrReg <= nextAddr;
        txShift <= regBank[nextAddr];
      end
      if (strobes.shiftOut) begin
        txBit   <= txShift[DATA_W-1];
        txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regBank[i] <= '0;
    end else if (strobes.blockDone && !readMode) begin
      regBank[addrReg] <= rxNext;
    end
  end

  // R5
  inc_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blockDone && incFlag |=> addrReg == $past(addrReg) + ADDR_W'(1));

  // R6
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.blockDone && !incFlag |=> $stable(addrReg));
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic sdi,
  input  logic threeWire,
  output logic sdo,
  output logic sdoOe,
  output logic sdioOut,
  output logic sdioOe
);
  spiStrobes_t strobes;
  logic sdiBit, readMode, txBit, driveOe;

  spi_reg_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csNPin(csN), .sclkPin(sclk), .sdiPin(sdi),
    .readMode(readMode), .strobes(strobes), .sdiBit(sdiBit), .driveOe(driveOe)
  );

  spi_reg_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdiBit(sdiBit),
    .readMode(readMode), .txBit(txBit)
  );

  assign sdo     = txBit;
  assign sdioOut = txBit;
  assign sdoOe   = driveOe && !threeWire;
  assign sdioOe  = driveOe && threeWire;

  // R8
  three_wire_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    threeWire |-> !sdoOe);

  // R9
  one_pin_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdoOe, sdioOe}));
endmodule

// File: tb/spi_reg_slave_tb.sv
`timescale 1ns/1ps
module spi_reg_slave_tb;
  localparam int HALF = 120;

  logic clk = 1'b0;
  logic rstN = 1'b0, csN = 1'b1, sclk = 1'b1, sdi = 1'b0, threeWire = 1'b0;
  logic sdo, sdoOe, sdioOut, sdioOe;

  int nChecks = 0, nFails = 0;
  logic [7:0] model [64];
  logic [7:0] txB [0:71];
  logic [7:0] rxB [0:71];
  bit sawCmdOe, sawWrongOe, missOe;

  always #10 clk = ~clk;

  spi_reg_slave u_dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdi(sdi),
    .threeWire(threeWire), .sdo(sdo), .sdoOe(sdoOe),
    .sdioOut(sdioOut), .sdioOe(sdioOe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37) + 5);
  endfunction

  function automatic logic [7:0] cmdByte(input bit rw, input bit inc, input int addr);
    return {rw, inc, 6'(addr)};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit tw, input int cutBits);
    threeWire = tw;
    sawCmdOe = 0; sawWrongOe = 0; missOe = 0;
    csN = 1'b0;
    #(HALF);
    for (int b = 0; b < cutBits; b++) begin
      sclk = 1'b0;
      sdi = txB[b / 8][7 - (b % 8)];
      #(HALF - 20);
      if (tw ? sdioOe : sdoOe) begin
        if (b < 8) sawCmdOe = 1;
      end else if (b >= 8 && txB[0][7]) missOe = 1;
      if (tw ? sdoOe : sdioOe) sawWrongOe = 1;
      rxB[b / 8][7 - (b % 8)] = tw ? sdioOut : sdo;
      #20;
      sclk = 1'b1;
      #(HALF);
    end
    csN = 1'b1;
    #(2 * HALF);
    check("R1 oe low after cs high", {sdoOe, sdioOe}, 0);
  endtask

  task automatic readRegs(input bit tw, input bit inc, input int addr, input int n, input string req);
    txB[0] = cmdByte(1'b1, inc, addr);
    for (int i = 1; i <= n; i++) txB[i] = 8'h00;
    xfer(tw, (n + 1) * 8);
    for (int i = 0; i < n; i++)
      check(req, rxB[i + 1], model[inc ? (addr + i) % 64 : addr]);
    check("R4 no oe in command byte", sawCmdOe, 0);
    check("R4 oe held through data", missOe, 0);
    check(tw ? "R8 dedicated pin quiet" : "R9 shared pin quiet", sawWrongOe, 0);
  endtask

  task automatic writeRegs(input bit tw, input bit inc, input int addr, input int n);
    txB[0] = cmdByte(1'b0, inc, addr);
    for (int i = 0; i < n; i++) model[inc ? (addr + i) % 64 : addr] = txB[i + 1];
    xfer(tw, (n + 1) * 8);
    check("R4 no oe on write", sawCmdOe | missOe & 1'b0, 0);
  endtask

  initial begin
    #(20 * 180000);
    nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    #105;
    check("R1 reset sdoOe", sdoOe, 0);
    check("R1 reset sdioOe", sdioOe, 0);
    rstN = 1'b1;
    #40;

    // R10: whole bank reads zero after reset
    readRegs(1'b0, 1'b1, 0, 64, "R10 reset value");

    // R3 R5: incrementing burst writes every register
    for (int i = 0; i < 64; i++) txB[i + 1] = pat(i);
    writeRegs(1'b0, 1'b1, 0, 64);
    // R5: read back from offset 10, crossing the 63 -> 0 wrap
    readRegs(1'b0, 1'b1, 10, 64, "R5 burst read with wrap");

    // R2: address 42 is 101010 sent MSB first; 21 would be the reversed order
    txB[1] = 8'h3C;
    writeRegs(1'b0, 1'b0, 42, 1);
    readRegs(1'b0, 1'b0, 42, 1, "R2 address bit order");
    readRegs(1'b0, 1'b0, 21, 1, "R2 reversed address untouched");

    // R3: single 16-clock write, MSB-first data
    txB[1] = 8'hA5;
    writeRegs(1'b0, 1'b0, 63, 1);
    readRegs(1'b0, 1'b0, 63, 1, "R3 single write");

    // R6: repeated blocks to one address
    txB[1] = 8'h11; txB[2] = 8'h22; txB[3] = 8'h33;
    writeRegs(1'b0, 1'b0, 20, 3);
    readRegs(1'b0, 1'b0, 20, 2, "R6 same-address read");
    readRegs(1'b0, 1'b0, 21, 1, "R6 neighbour untouched");

    // R7: abort five bits into the data byte
    txB[0] = cmdByte(1'b0, 1'b0, 30); txB[1] = 8'hFF;
    xfer(1'b0, 13);
    readRegs(1'b0, 1'b0, 30, 1, "R7 partial data byte dropped");
    // R7: abort inside the command byte, then a full write
    txB[0] = cmdByte(1'b0, 1'b0, 31);
    xfer(1'b0, 4);
    txB[1] = 8'h5A;
    writeRegs(1'b0, 1'b0, 31, 1);
    readRegs(1'b0, 1'b0, 31, 1, "R7 recovery after command abort");
    // R7: abort inside the second block of a burst
    txB[0] = cmdByte(1'b0, 1'b1, 40); txB[1] = 8'h77; txB[2] = 8'h88;
    model[40] = 8'h77;
    xfer(1'b0, 19);
    readRegs(1'b0, 1'b1, 40, 2, "R7 second block dropped");

    // R8: three-wire burst read with wrap, then three-wire write
    readRegs(1'b1, 1'b1, 60, 8, "R8 three-wire read");
    txB[1] = 8'hC3;
    writeRegs(1'b1, 1'b0, 5, 1);
    readRegs(1'b1, 1'b0, 5, 1, "R8 three-wire write");
    // R9: back to four-wire
    readRegs(1'b0, 1'b0, 5, 1, "R9 four-wire read");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule